// File: doc/BRIEF.md
# Gate-Driver Standby Sequencer

This block decides when a half-bridge gate driver drops into a low-power sleep and when it comes back. It adds no dedicated sleep pin. The decision comes only from timed patterns on the four ordinary logic inputs:

- an active-low off input;
- an active-low low-side-force input;
- two channel command inputs.

The sleep pattern is the off input low while the other three inputs are high. Holding that pattern long enough puts the driver to sleep. Waking takes two timed steps. First, any other pattern is held through a filter window. Then the sleep pattern is applied again as a pulse whose length falls inside a bounded window.

The block has four outputs:

- a sleep flag that gates quiescent circuits;
- an output-enable flag;
- the two gate commands, which follow the input truth table only while the driver is enabled.

Every duration is counted in clock cycles against four parameters: the entry time `T_ENTRY`, the exit filter time `T_FILT`, the wake lower bound `T_WUP` and the awake delay `T_AWAKE`. All outputs are registered.

Each input sample is one clock cycle. A pattern that is "held N cycles" is seen unchanged on N consecutive rising edges. The input vector is written {off_n, lsforce_n, cmd_a, cmd_b}, and the sleep pattern is 4'b0111.

Top module: `gdsb_standby_ctrl`

## Requirements
- R1: After reset every output is 0. With no sleep request, `drv_en_o` goes to 1 exactly `T_AWAKE` cycles after the first clock of the settle period that follows reset. Before that, the gate outputs stay 0.
- R2: While enabled, the gate outputs follow the inputs as below. Their value lags the input by two clock edges.
  - off_n=0 gives both gates 0.
  - off_n=1 and lsforce_n=0 give drv_a=0 and drv_b=1.
  - Otherwise drv_a = cmd_a & ~cmd_b and drv_b = cmd_b & ~cmd_a.
- R3: `drv_a_o` and `drv_b_o` are never 1 together. Both command inputs high gives both gates 0.
- R4: The sleep pattern held for `T_ENTRY`+1 or more samples sets `qsleep_o`. Held for only `T_ENTRY` samples, it does not.
- R5: While `qsleep_o` is 1, `drv_en_o` and both gates are 0. While asleep, input patterns held no longer than `T_FILT` samples leave the block asleep.
- R6: The wake sequence is armed only when a pattern other than the sleep pattern has been held for more than `T_FILT` samples. A correct wake pulse that comes before arming leaves the block asleep.
- R7: Once armed, a sleep-pattern pulse of length t with `T_WUP` < t < `T_ENTRY` wakes the block when the pulse is released. `qsleep_o` clears, and `drv_en_o` rises `T_AWAKE` cycles later.
- R8: A wake pulse of `T_WUP` samples or fewer keeps the block asleep and still armed. A later valid pulse then wakes it without a new filter period.
- R9: A wake pulse that reaches `T_ENTRY` samples keeps the block asleep and clears the armed state. A new filter period is then needed before any wake.
- R10: Every duration count restarts when the sampled input pattern changes. A one-cycle break inside the sleep pattern therefore restarts the entry timing.
- R11: The parameters must satisfy `T_FILT` > 0, `T_AWAKE` > 0 and `T_WUP` < `T_ENTRY`. A violation is reported at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| off_n_i | input | 1 | Active-low off request |
| lsforce_n_i | input | 1 | Active-low low-side force |
| cmd_a_i | input | 1 | Channel A command |
| cmd_b_i | input | 1 | Channel B command |
| qsleep_o | output | 1 | Sleep flag, gates quiescent circuits |
| drv_en_o | output | 1 | Output stage enabled |
| drv_a_o | output | 1 | Gate command, channel A |
| drv_b_o | output | 1 | Gate command, channel B |

## Verification
The assertions check four properties on every cycle:
- the two gates are never high together;
- sleep forces every output low;
- the gates are high only while enabled;
- sleep begins only just after the sleep pattern was sampled, and leaving sleep always passes through a disabled settle period.

The exact durations can only be shown by the bench's timed scenarios, which run against a behavioural cycle model. These include the `T_ENTRY` boundary, the filter length, the short, valid and over-long wake pulses, and the restart of counts after a one-cycle break.

// File: rtl/gdsb_pkg.sv
package gdsb_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_HOLD   = 3'd2,
    ST_ARMED  = 3'd3,
    ST_WAKE   = 3'd4
  } sb_state_e;

  // pattern order {off_n, lsforce_n, cmd_a, cmd_b}
  localparam logic [3:0] SLEEP_PAT = 4'b0111;

  // returns {drv_a, drv_b}
  function automatic logic [1:0] drive_map(input logic [3:0] p);
    logic [1:0] r;
    if (!p[3])      r = 2'b00;
    else if (!p[2]) r = 2'b01;
    else            r = {p[1] & ~p[0], p[0] & ~p[1]};
    return r;
  endfunction

endpackage

// File: rtl/gdsb_pattern_timer.sv
module gdsb_pattern_timer #(
  parameter int PW  = 4,
  parameter int SAT = 41,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pat_i,
  output logic [PW-1:0] pat_o,
  output logic [CW-1:0] run_o,
  output logic [CW-1:0] last_o
);

  logic [PW-1:0] pat_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] last_q;

  // run_q: samples the current pattern has been seen; last_q: length of the previous run
  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q  <= '0;
      run_q  <= '0;
      last_q <= '0;
    end else if (pat_i != pat_q) begin
      pat_q  <= pat_i;
      run_q  <= CW'(1);
      last_q <= run_q;
    end else if (run_q < CW'(SAT)) begin
      run_q <= run_q + CW'(1);
    end
  end

  assign pat_o  = pat_q;
  assign run_o  = run_q;
  assign last_o = last_q;

endmodule

// File: rtl/gdsb_seq_fsm.sv
module gdsb_seq_fsm
  import gdsb_pkg::*;
#(
  parameter int T_ENTRY = 40,
  parameter int T_FILT  = 8,
  parameter int T_WUP   = 10,
  parameter int T_AWAKE = 6,
  parameter int CW      = 6,
  parameter int DW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    pat_i,
  input  logic [CW-1:0] run_i,
  input  logic [CW-1:0] last_i,
  output sb_state_e     state_o,
  output sb_state_e     next_o
);

  sb_state_e     st_q, st_n;
  logic [DW-1:0] dly_q, dly_n;
  logic          on_sleep;
  logic          entry_ok;

  assign on_sleep = (pat_i == SLEEP_PAT);
  assign entry_ok = on_sleep && (run_i > CW'(T_ENTRY));

  always_comb begin
    st_n  = st_q;
    dly_n = dly_q;
    case (st_q)
      ST_SETTLE: begin
        if (entry_ok)                      st_n = ST_HOLD;
        else if (dly_q >= DW'(T_AWAKE - 1)) st_n = ST_ACTIVE;
        else                               dly_n = dly_q + DW'(1);
      end
      ST_ACTIVE: if (entry_ok) st_n = ST_HOLD;
      ST_HOLD:   if (!on_sleep && (run_i > CW'(T_FILT))) st_n = ST_ARMED;
      ST_ARMED:  if (on_sleep) st_n = ST_WAKE;
      ST_WAKE: begin
        if (on_sleep) begin
          if (run_i >= CW'(T_ENTRY)) st_n = ST_HOLD;
        end else if (last_i > CW'(T_WUP)) begin
          st_n  = ST_SETTLE;
          dly_n = '0;
        end else begin
          st_n = ST_ARMED;
        end
      end
      default: st_n = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_SETTLE;
      dly_q <= '0;
    end else begin
      st_q  <= st_n;
      dly_q <= dly_n;
    end
  end

  assign state_o = st_q;
  assign next_o  = st_n;

  AST_ARM_NEEDS_OTHER: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && st_n == ST_ARMED) |-> !on_sleep); // R6

endmodule

// File: rtl/gdsb_out_stage.sv
module gdsb_out_stage
  import gdsb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sb_state_e next_i,
  input  logic [3:0] pat_i,
  output logic      sleep_o,
  output logic      en_o,
  output logic      a_o,
  output logic      b_o
);

  logic       en_n;
  logic [1:0] map;

  assign en_n = (next_i == ST_ACTIVE);
  assign map  = drive_map(pat_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_o <= 1'b0;
      en_o    <= 1'b0;
      a_o     <= 1'b0;
      b_o     <= 1'b0;
    end else begin
      sleep_o <= (next_i == ST_HOLD) || (next_i == ST_ARMED) || (next_i == ST_WAKE);
      en_o    <= en_n;
      a_o     <= en_n & map[1];
      b_o     <= en_n & map[0];
    end
  end

endmodule

// File: rtl/gdsb_standby_ctrl.sv
module gdsb_standby_ctrl
  import gdsb_pkg::*;
#(
  parameter int T_ENTRY = 40,
  parameter int T_FILT  = 8,
  parameter int T_WUP   = 10,
  parameter int T_AWAKE = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic off_n_i,
  input  logic lsforce_n_i,
  input  logic cmd_a_i,
  input  logic cmd_b_i,
  output logic qsleep_o,
  output logic drv_en_o,
  output logic drv_a_o,
  output logic drv_b_o
);

  localparam int MAXT = (T_ENTRY > T_FILT) ? ((T_ENTRY > T_WUP) ? T_ENTRY : T_WUP)
                                           : ((T_FILT > T_WUP) ? T_FILT : T_WUP);
  localparam int SAT  = MAXT + 1;
  localparam int CW   = $clog2(SAT + 1);
  localparam int DW   = $clog2(T_AWAKE + 1);

  // R11: parameter sanity
  initial begin
    if (!(T_FILT > 0 && T_AWAKE > 0 && T_WUP < T_ENTRY))
      $error("gdsb_standby_ctrl: need T_FILT>0, T_AWAKE>0, T_WUP<T_ENTRY");
  end

  logic [3:0]    pat_raw, pat_q;
  logic [CW-1:0] run, last;
  sb_state_e     st_cur, st_nxt;

  assign pat_raw = {off_n_i, lsforce_n_i, cmd_a_i, cmd_b_i};

  gdsb_pattern_timer #(.PW(4), .SAT(SAT), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .pat_i(pat_raw),
    .pat_o(pat_q), .run_o(run), .last_o(last)
  );

  gdsb_seq_fsm #(
    .T_ENTRY(T_ENTRY), .T_FILT(T_FILT), .T_WUP(T_WUP), .T_AWAKE(T_AWAKE),
    .CW(CW), .DW(DW)
  ) u_fsm (
    .clk(clk), .rst(rst), .pat_i(pat_q), .run_i(run), .last_i(last),
    .state_o(st_cur), .next_o(st_nxt)
  );

  gdsb_out_stage u_out (
    .clk(clk), .rst(rst), .next_i(st_nxt), .pat_i(pat_q),
    .sleep_o(qsleep_o), .en_o(drv_en_o), .a_o(drv_a_o), .b_o(drv_b_o)
  );

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(drv_a_o && drv_b_o)); // R3
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    qsleep_o |-> (!drv_en_o && !drv_a_o && !drv_b_o)); // R5
  AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (drv_a_o || drv_b_o) |-> drv_en_o); // R1
  AST_ENTRY_ON_PATTERN: assert property (@(posedge clk) disable iff (rst)
    $rose(qsleep_o) |-> $past(pat_q == SLEEP_PAT)); // R4
  AST_WAKE_SETTLES: assert property (@(posedge clk) disable iff (rst)
    $fell(qsleep_o) |-> !drv_en_o); // R7
  AST_FSM_LEGAL: assert property (@(posedge clk) disable iff (rst)
    st_cur inside {ST_SETTLE, ST_ACTIVE, ST_HOLD, ST_ARMED, ST_WAKE}); // R5

endmodule

// File: tb/test_gdsb_standby_ctrl.sv
module test_gdsb_standby_ctrl;

  localparam int TE = 40;
  localparam int TF = 8;
  localparam int TW = 10;
  localparam int TA = 6;
  localparam int SATV = TE + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic off_n = 1'b1, lsf_n = 1'b1, ca = 1'b0, cb = 1'b0;
  logic qsleep, den, da, db;

  always #2 clk = ~clk;

  gdsb_standby_ctrl #(.T_ENTRY(TE), .T_FILT(TF), .T_WUP(TW), .T_AWAKE(TA)) i_gdsb_standby_ctrl (
    .clk(clk), .rst(rst), .off_n_i(off_n), .lsforce_n_i(lsf_n), .cmd_a_i(ca), .cmd_b_i(cb),
    .qsleep_o(qsleep), .drv_en_o(den), .drv_a_o(da), .drv_b_o(db)
  );

  int total = 0, bad = 0, cycles = 0;
  string req = "R1";
  bit done = 0;

  // behavioural reference: 0 settle, 1 active, 2 asleep, 3 armed, 4 pulse
  int m_st, m_d, m_run, m_last;
  logic [3:0] m_prev;
  logic e_sb, e_en, e_a, e_b;

  function automatic logic [1:0] ref_map(input logic [3:0] p);
    if (p[3] == 1'b0) return 2'b00;
    if (p[2] == 1'b0) return 2'b01;
    if (p[1] && p[0]) return 2'b00;
    return {p[1], p[0]};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = 0; m_d = 0; m_run = 0; m_last = 0; m_prev = 4'b0000;
      e_sb = 0; e_en = 0; e_a = 0; e_b = 0;
    end else begin
      int ns, nd;
      bit sp;
      logic [3:0] cur;
      logic [1:0] mp;
      sp = (m_prev == 4'b0111);
      ns = m_st; nd = m_d;
      if (m_st == 0) begin
        if (sp && m_run > TE) ns = 2;
        else if (m_d >= TA - 1) ns = 1;
        else nd = m_d + 1;
      end else if (m_st == 1) begin
        if (sp && m_run > TE) ns = 2;
      end else if (m_st == 2) begin
        if (!sp && m_run > TF) ns = 3;
      end else if (m_st == 3) begin
        if (sp) ns = 4;
      end else begin
        if (sp) begin
          if (m_run >= TE) ns = 2;
        end else if (m_last > TW) begin
          ns = 0; nd = 0;
        end else ns = 3;
      end
      mp = ref_map(m_prev);
      e_sb = (ns >= 2);
      e_en = (ns == 1);
      e_a = e_en & mp[1];
      e_b = e_en & mp[0];
      cur = {off_n, lsf_n, ca, cb};
      if (cur != m_prev) begin
        m_last = m_run; m_run = 1; m_prev = cur;
      end else if (m_run < SATV) m_run++;
      m_st = ns; m_d = nd;
    end
  end

  task automatic check(input string r, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs {sleep,en,a,b} got %b expected %b at cycle %0d", r, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) check(req, {qsleep, den, da, db}, {e_sb, e_en, e_a, e_b});
  end

  task automatic drive(input logic [3:0] p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {off_n, lsf_n, ca, cb} = p;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    check("R1", {qsleep, den, da, db}, 4'b0000);
    drive(4'b1110, 1);
    rst = 1'b0;
    drive(4'b1110, 3);
    check("R1", {qsleep, den, da, db}, 4'b0000);
    drive(4'b1110, 8);
    check("R1", {qsleep, den, da, db}, 4'b0110);

    req = "R2";
    for (int p = 0; p < 16; p++) begin
      if (p != 7) drive(4'(p), 4);
    end
    drive(4'b1101, 4);
    check("R2", {qsleep, den, da, db}, 4'b0101);
    drive(4'b1011, 4);
    check("R2", {qsleep, den, da, db}, 4'b0101);
    req = "R3";
    drive(4'b1111, 4);
    check("R3", {qsleep, den, da, db}, 4'b0100);

    req = "R10";
    drive(4'b0111, 30);
    drive(4'b1101, 1);
    drive(4'b0111, 30);
    drive(4'b1100, 4);
    check("R10", {qsleep, den, da, db}, 4'b0100);

    req = "R4";
    drive(4'b0111, TE);
    drive(4'b1110, 4);
    check("R4", {qsleep, den, da, db}, 4'b0110);
    drive(4'b0111, TE + 5);
    check("R4", {qsleep, den, da, db}, 4'b1000);

    req = "R5";
    drive(4'b1011, 3);
    drive(4'b1100, 3);
    drive(4'b0000, 3);
    drive(4'b1110, 3);
    check("R5", {qsleep, den, da, db}, 4'b1000);

    req = "R6";
    drive(4'b1100, TF);
    drive(4'b0111, 20);
    drive(4'b1100, 6);
    check("R6", {qsleep, den, da, db}, 4'b1000);

    req = "R8";
    drive(4'b1100, TF + 4);
    drive(4'b0111, TW);
    drive(4'b1100, 3);
    check("R8", {qsleep, den, da, db}, 4'b1000);
    req = "R7";
    drive(4'b0111, 20);
    drive(4'b1110, 4);
    check("R7", {qsleep, den, da, db}, 4'b0000);
    drive(4'b1110, TA + 2);
    check("R7", {qsleep, den, da, db}, 4'b0110);

    req = "R9";
    drive(4'b0111, TE + 5);
    drive(4'b1100, TF + 4);
    drive(4'b0111, TE);
    drive(4'b1100, 3);
    drive(4'b0111, 20);
    drive(4'b1100, 6);
    check("R9", {qsleep, den, da, db}, 4'b1000);
    drive(4'b1100, TF + 4);
    drive(4'b0111, 15);
    drive(4'b1010, TA + 6);
    check("R9", {qsleep, den, da, db}, 4'b0101);

    drive(4'b1110, 4);
    finish_run();
  end

endmodule